// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Transmitter

This block turns one byte plus an extra ninth bit into an eleven-bit asynchronous frame on a single output line. A host writes the byte and the ninth bit with a one-cycle strobe. The block does not start the frame on the strobe. It waits for the next rollover of a free-running phase counter that counts a baud tick at sixteen times the bit rate. One frame bit is then driven on each rollover. A sticky done flag rises in the same clock as the stop bit reaches the line, and stays up until software clears it.

The control is a three-state machine. `ST_IDLE` waits for a write. The transition *accept* (a strobe in `ST_IDLE`) captures the frame and moves to `ST_ARMED`. The transition *launch* (a rollover in `ST_ARMED`) drives the start bit and moves to `ST_SHIFT`. The transition *advance* (a rollover in `ST_SHIFT` before the last bit) drives the next bit. The transition *finish* (the rollover that drives the stop bit) sets the done flag and returns to `ST_IDLE`. The line stays high there. A new write may then arm the next frame, which launches on the following rollover, so every stop bit lasts at least one full bit time. The baud tick comes from outside, so the bit time can be any multiple of the clock, for example 1/32 or 1/64 of the oscillator.

Top module: `nine_bit_uart_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tx_line` is 1 and `tx_done` is 0.
- R2: A frame is, in the order sent: a start bit of 0, `wr_data[0]` through `wr_data[7]`, the captured `wr_bit9`, then a stop bit of 1. Each bit holds for 16 baud ticks.
- R3: The start bit appears on the first phase-counter rollover strictly after the accepted write, never on the write itself. A rollover is a cycle with `baud_tick` high while the phase is 15.
- R4: `tx_done` rises on the 11th rollover after the accepted write, in the same clock in which the stop bit is driven.
- R5: `tx_done` stays 1 until `done_clr` is sampled high. If the flag is set and cleared in the same cycle, the set wins.
- R6: A write strobe while a frame is armed or being sent is ignored. It changes neither the frame on the line nor its timing.
- R7: The phase counter runs freely from reset. Neither writes nor frames reset or restart it, so frame timing follows the counter phase at the moment of the write.
- R8: `tx_line` is 1 whenever no frame is in progress. A write in the cycle after `tx_done` rises is accepted, and its frame starts on the next rollover.
- R9: The phase counter advances only in cycles with `baud_tick` high, so irregular tick spacing stretches the bits but keeps 16 ticks per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_stb | input | 1 | Write strobe for a new frame |
| wr_data | input | 8 | Byte to send, least significant bit first |
| wr_bit9 | input | 1 | Ninth bit, sent after the byte |
| done_clr | input | 1 | Clears the done flag |
| tx_line | output | 1 | Serial output, idles high |
| tx_done | output | 1 | Sticky transmit-done flag |

## Verification
Every result is registered. A rollover in clock N changes `tx_line` after edge N, and the 11th rollover also raises `tx_done` after that same edge. A `done_clr` in clock N drops the flag after edge N. The bench drives inputs on the falling edge and updates its model from the inputs of that cycle. It then compares both outputs 1 ns after the next rising edge, so the expected value always belongs to the edge that just produced it. The tick density, write timing and clear pulses change from phase to phase, and one phase lines a clear up with the stop-bit rollover to test set priority.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2
    } tx_state_t;
endpackage

// File: rtl/uart9_slice_ctr.sv
module uart9_slice_ctr #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic rollover
);
    localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    logic [CW-1:0] phase;

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (tick)
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end

    assign rollover = tick && (phase == LAST);

    // R9: phase only moves with a tick
    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase));
    // R7: wrap returns to zero
    p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rollover |=> (phase == '0));
endmodule

// File: rtl/uart9_frame_sreg.sv
module uart9_frame_sreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] data,
    input  logic              bit9,
    output logic              line
);
    localparam int FW = DATA_W + 3;

    logic [FW-1:0] sreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '1;
            line <= 1'b1;
        end else if (load) begin
            sreg <= {1'b1, bit9, data, 1'b0};
        end else if (shift) begin
            line <= sreg[0];
            sreg <= {1'b1, sreg[FW-1:1]};
        end
    end

    // R2: the line only changes on a bit boundary
    p_line_on_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(line));
endmodule

// File: rtl/uart9_ctrl.sv
module uart9_ctrl
    import uart9_pkg::*;
#(
    parameter int FW = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rollover,
    input  logic wr_stb,
    input  logic done_clr,
    output logic load,
    output logic shift,
    output logic tx_done
);
    localparam int IW = $clog2(FW + 1);
    localparam logic [IW-1:0] LAST_SENT = IW'(FW - 1);

    tx_state_t     state, nxt;
    logic [IW-1:0] sent;
    logic          done_set;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sent    <= '0;
            tx_done <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_ARMED && rollover)
                sent <= IW'(1);
            else if (state == ST_SHIFT && rollover)
                sent <= sent + 1'b1;
            if (done_set)
                tx_done <= 1'b1;
            else if (done_clr)
                tx_done <= 1'b0;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (wr_stb)                          nxt = ST_ARMED;
            ST_ARMED: if (rollover)                        nxt = ST_SHIFT;
            ST_SHIFT: if (rollover && sent == LAST_SENT)   nxt = ST_IDLE;
            default:                                       nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        load     = (state == ST_IDLE) && wr_stb;
        shift    = (state != ST_IDLE) && rollover;
        done_set = (state == ST_SHIFT) && rollover && (sent == LAST_SENT);
    end

    // R3: an armed frame waits for a rollover
    p_armed_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !rollover) |=> (state == ST_ARMED));
    // R4: done rises only on the final rollover of a frame
    p_done_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> $past(state == ST_SHIFT && rollover));
    // R5: done is sticky without a clear
    p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !done_clr) |=> tx_done);
    // R6: a busy frame is not disturbed between bit boundaries
    p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !rollover) |=> (state == ST_SHIFT && $stable(sent)));
endmodule

// File: rtl/nine_bit_uart_tx.sv
module nine_bit_uart_tx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit9,
    input  logic              done_clr,
    output logic              tx_line,
    output logic              tx_done
);
    localparam int FW = DATA_W + 3;

    logic rollover;
    logic load;
    logic shift;

    uart9_slice_ctr #(.OVS(OVS)) u_slice (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .rollover (rollover)
    );

    uart9_ctrl #(.FW(FW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rollover (rollover),
        .wr_stb   (wr_stb),
        .done_clr (done_clr),
        .load     (load),
        .shift    (shift),
        .tx_done  (tx_done)
    );

    uart9_frame_sreg #(.DATA_W(DATA_W)) u_sreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (shift),
        .data  (wr_data),
        .bit9  (wr_bit9),
        .line  (tx_line)
    );

    // R2: the stop bit is high when done rises
    p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> tx_line);
endmodule

// File: tb/test_nine_bit_uart_tx.sv
module test_nine_bit_uart_tx;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       baud_tick;
    logic       wr_stb;
    logic [7:0] wr_data;
    logic       wr_bit9;
    logic       done_clr;
    logic       tx_line;
    logic       tx_done;

    always #4 clk = ~clk;

    nine_bit_uart_tx i_nine_bit_uart_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .wr_bit9   (wr_bit9),
        .done_clr  (done_clr),
        .tx_line   (tx_line),
        .tx_done   (tx_done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // model state: 0 idle, 1 armed, 2 sending
    int        m_cnt;
    int        m_busy;
    int        m_idx;
    logic      m_line;
    logic      m_done;
    logic [10:0] m_frame;

    task automatic chk(string tag, string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [10:0] frame_of(logic [7:0] d, logic b9);
        return {1'b1, b9, d, 1'b0};
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_busy = 0; m_idx = 0;
        m_line = 1'b1; m_done = 1'b0; m_frame = '1;
    endtask

    task automatic step(logic tk, logic wr, logic [7:0] d, logic b9, logic clr,
                        string tag, string dtag);
        logic roll;
        logic nd;
        int   ob;
        @(negedge clk);
        baud_tick = tk; wr_stb = wr; wr_data = d; wr_bit9 = b9; done_clr = clr;
        roll = tk && (m_cnt == 15);
        nd = m_done;
        if (clr) nd = 1'b0;
        ob = m_busy;
        if (ob == 1 && roll) begin
            m_line = m_frame[0]; m_idx = 1; m_busy = 2;
        end else if (ob == 2 && roll) begin
            m_line = m_frame[m_idx];
            if (m_idx == 10) begin nd = 1'b1; m_busy = 0; end
            else m_idx++;
        end
        if (ob == 0 && wr) begin
            m_frame = frame_of(d, b9); m_busy = 1;
        end
        if (tk) m_cnt = (m_cnt + 1) % 16;
        m_done = nd;
        @(posedge clk);
        #1;
        chk(tag, "tx_line", tx_line, m_line);
        chk(dtag, "tx_done", tx_done, m_done);
    endtask

    // wr_mode: 0 occasional writes, 1 writes spammed, 2 write whenever idle
    task automatic run_phase(string tag, int cycles, int tick_pct, int wr_mode, int clr_pct);
        for (int i = 0; i < cycles; i++) begin
            logic tk, wr, clr;
            tk = (($urandom % 100) < tick_pct);
            case (wr_mode)
                0: wr = (($urandom % 40) == 0);
                1: wr = (($urandom % 2) == 0);
                default: wr = (m_busy == 0);
            endcase
            clr = (($urandom % 100) < clr_pct);
            if (tag == "R5" && tk && m_busy == 2 && m_idx == 10 && m_cnt == 15)
                clr = 1'b1;
            step(tk, wr, 8'($urandom), 1'($urandom), clr, tag,
                 (tag == "R5") ? "R5" : "R4");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; baud_tick = 1'b1; wr_stb = 1'b1; wr_data = 8'hA5;
        wr_bit9 = 1'b1; done_clr = 1'b0;
        model_reset();
        repeat (4) @(posedge clk);
        #1;
        chk("R1", "tx_line in reset", tx_line, 1'b1);
        chk("R1", "tx_done in reset", tx_done, 1'b0);
        @(negedge clk);
        rst_n = 1'b1; baud_tick = 1'b0; wr_stb = 1'b0;
        @(posedge clk);
        #1;
        chk("R1", "tx_line after reset", tx_line, 1'b1);
        chk("R1", "tx_done after reset", tx_done, 1'b0);
        // model was reset; the idle cycle above did not tick
        // directed R3: write at phase 5 with a tick every cycle
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R3", "R4");
        step(1'b1, 1'b1, 8'h3C, 1'b0, 1'b0, "R3", "R4");
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R3", "R4");
        // directed R2: all-ones byte with ninth bit zero, then alternating
        step(1'b1, 1'b1, 8'hFF, 1'b0, 1'b1, "R2", "R5");
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R2", "R4");
        step(1'b1, 1'b1, 8'h55, 1'b1, 1'b1, "R2", "R5");
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R2", "R4");
        run_phase("R2", 3000, 100, 0, 3);
        run_phase("R3", 3000, 100, 0, 2);
        run_phase("R7", 3000, 70, 0, 2);
        run_phase("R6", 3000, 100, 1, 2);
        run_phase("R9", 8000, 30, 0, 1);
        run_phase("R5", 4000, 100, 2, 10);
        run_phase("R8", 3000, 100, 2, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule